// File: doc/BRIEF.md
# Peripheral Interface Interrupt and Register Unit

This block is the register side of a classic parallel peripheral interface chip. A byte-wide register bus selects one of sixteen register slots with four address lines. Seven interrupt sources each deliver single-cycle pulses. Each pulse latches a flag. A separate enable mask decides which latched flags drive a single active-high interrupt request. Software clears flags by writing ones to them. Software changes the enable mask by writing a byte whose top bit says whether the low seven bits are to be set or cleared.

The block also holds the port B output byte. A two-bit bus-state field sits at bits [5:4] of that byte, and neighbouring logic decodes it. Whenever a write changes that field, the block emits a one-cycle strobe together with the previous and the new field values. Port A, the two direction registers, the shift register and the two control registers are plain storage. Index 15 is a second path to the port A register. Reads are combinational from the selected slot. Writes take effect at the clock edge.

Top module: `via_irq_unit`

## Requirements
- R1: A synchronous active-high reset clears all flags, all enables and every storage register. After reset, irq is 0, the enable register reads 0x80, the flag register reads 0x00 and bus_chg is 0.
- R2: A pulse on src_pulse[i] sets flag i at the next clock edge, whatever the state of enable bit i.
- R3: irq is 1 exactly when some bit position holds both a set flag and a set enable. irq follows register changes without further delay, so it rises in the cycle after an enable write that unmasks a pending flag.
- R4: A write to index 14 with data bit 7 = 1 sets every enable bit whose data bit in [6:0] is 1. With data bit 7 = 0 it clears those enable bits. Every other enable bit keeps its value.
- R5: A read of index 14 returns 1 in bit 7 and the enable bits in [6:0].
- R6: A read of index 13 returns the flags in [6:0]. Bit 7 of that read is 1 when any flag is both set and enabled.
- R7: A write to index 13 clears each flag whose data bit is 1 and leaves the other flags unchanged.
- R8: If a pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: The register select is addr[12:9]. Indices 0 (port B), 1 (port A), 2 (port B direction), 3 (port A direction), 10 (shift), 11 (auxiliary control) and 12 (peripheral control) read back the last byte written to them. Index 15 reads and writes the same register as index 1.
- R10: Suppose a write to index 0 carries bits [5:4] that differ from the stored field. Then bus_chg is 1 for exactly the next cycle, with bus_old holding the previous field and bus_new the written one. A write that leaves the field unchanged produces no strobe.
- R11: Indices 4 to 9 read as 0x00. Writes to them change no register, no flag and no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register select, address bits [12:9] |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| src_pulse | input | 7 | Single-cycle interrupt source pulses, one per flag |
| irq | output | 1 | Interrupt request, active high |
| bus_chg | output | 1 | One-cycle strobe on a change of port B bits [5:4] |
| bus_old | output | 2 | Field value before the change |
| bus_new | output | 2 | Field value after the change |

## Verification
A source pulse can arrive in the same cycle as a flag-clearing write to the flag register. The two can hit the same bit, or different bits. The bench forces the same-bit case directly. Random traffic mixes dense pulses with random writes to index 13, which covers both cases. After each cycle the bench reads back the flags and judges them against a model in which setting takes priority over clearing. An enable write that coincides with a pulse on a masked bit is also judged through irq and the read-back summary bit.

// File: rtl/via_irq_pkg.sv
package via_irq_pkg;

    localparam int DATA_W  = 8;
    localparam int NSRC    = DATA_W - 1;
    localparam int SEL_LSB = 9;
    localparam int SEL_W   = 4;
    localparam int SEL_MSB = SEL_LSB + SEL_W - 1;
    localparam int BST_LSB = 4;
    localparam int BST_W   = 2;

    typedef enum logic [SEL_W-1:0] {
        IDX_PB    = 4'd0,
        IDX_PA    = 4'd1,
        IDX_DIRB  = 4'd2,
        IDX_DIRA  = 4'd3,
        IDX_SHIFT = 4'd10,
        IDX_AUXC  = 4'd11,
        IDX_PERC  = 4'd12,
        IDX_FLAG  = 4'd13,
        IDX_ENAB  = 4'd14,
        IDX_PA_NH = 4'd15
    } reg_idx_e;

    typedef struct packed {
        logic [DATA_W-1:0] pb;
        logic [DATA_W-1:0] pa;
        logic [DATA_W-1:0] dirb;
        logic [DATA_W-1:0] dira;
        logic [DATA_W-1:0] shift;
        logic [DATA_W-1:0] auxc;
        logic [DATA_W-1:0] perc;
    } store_t;

    // Top data bit picks set (1) or clear (0) of the low mask bits.
    function automatic logic [NSRC-1:0] enab_update(input logic [NSRC-1:0] cur,
                                                    input logic [DATA_W-1:0] wd);
        if (wd[DATA_W-1]) return cur | wd[NSRC-1:0];
        else              return cur & ~wd[NSRC-1:0];
    endfunction

    function automatic logic [BST_W-1:0] bst_field(input logic [DATA_W-1:0] v);
        return v[BST_LSB +: BST_W];
    endfunction

endpackage

// File: rtl/via_irq_flags.sv
module via_irq_flags
    import via_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_pulse,
    input  logic              flag_wr,
    input  logic              enab_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NSRC-1:0]   flags,
    output logic [NSRC-1:0]   enables,
    output logic              irq
);

    logic [NSRC-1:0] clr_mask;
    logic [NSRC-1:0] flags_nxt;
    logic [NSRC-1:0] enab_nxt;

    always_comb begin
        clr_mask  = flag_wr ? wdata[NSRC-1:0] : '0;
        flags_nxt = (flags & ~clr_mask) | src_pulse;
        enab_nxt  = enab_wr ? enab_update(enables, wdata) : enables;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            enables <= '0;
        end else begin
            flags   <= flags_nxt;
            enables <= enab_nxt;
        end
    end

    assign irq = |(flags & enables);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|src_pulse) |=> ((flags & $past(src_pulse)) == $past(src_pulse)));

    // R7
    clear_bits_chk: assert property (@(posedge clk) disable iff (rst)
        flag_wr |=> ((flags & $past(wdata[NSRC-1:0] & ~src_pulse)) == '0));

    // R4
    enab_set_chk: assert property (@(posedge clk) disable iff (rst)
        (enab_wr && wdata[DATA_W-1])
            |=> ((enables & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0])));

    // R3
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (enables == '0) |-> !irq);

endmodule

// File: rtl/via_port_store.sv
module via_port_store
    import via_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  reg_idx_e          idx,
    input  logic [DATA_W-1:0] wdata,
    output store_t            regs,
    output logic              bst_chg,
    output logic [BST_W-1:0]  bst_old,
    output logic [BST_W-1:0]  bst_new
);

    logic pb_hit;
    logic field_differs;

    assign pb_hit        = wr && (idx == IDX_PB);
    assign field_differs = bst_field(wdata) != bst_field(regs.pb);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (wr) begin
            case (idx)
                IDX_PB:             regs.pb    <= wdata;
                IDX_PA, IDX_PA_NH:  regs.pa    <= wdata;
                IDX_DIRB:           regs.dirb  <= wdata;
                IDX_DIRA:           regs.dira  <= wdata;
                IDX_SHIFT:          regs.shift <= wdata;
                IDX_AUXC:           regs.auxc  <= wdata;
                IDX_PERC:           regs.perc  <= wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bst_chg <= 1'b0;
            bst_old <= '0;
            bst_new <= '0;
        end else begin
            bst_chg <= pb_hit && field_differs;
            if (pb_hit && field_differs) begin
                bst_old <= bst_field(regs.pb);
                bst_new <= bst_field(wdata);
            end
        end
    end

    // R10
    strobe_values_chk: assert property (@(posedge clk) disable iff (rst)
        bst_chg |-> (bst_old != bst_new) && (bst_field(regs.pb) == bst_new));

endmodule

// File: rtl/via_irq_unit.sv
module via_irq_unit
    import via_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SEL_MSB:SEL_LSB] reg_addr,
    input  logic                 reg_wr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NSRC-1:0]      src_pulse,
    output logic                 irq,
    output logic                 bus_chg,
    output logic [BST_W-1:0]     bus_old,
    output logic [BST_W-1:0]     bus_new
);

    reg_idx_e        idx;
    store_t          regs;
    logic [NSRC-1:0] flags;
    logic [NSRC-1:0] enables;

    assign idx = reg_idx_e'(reg_addr);

    via_irq_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .src_pulse (src_pulse),
        .flag_wr   (reg_wr && idx == IDX_FLAG),
        .enab_wr   (reg_wr && idx == IDX_ENAB),
        .wdata     (reg_wdata),
        .flags     (flags),
        .enables   (enables),
        .irq       (irq)
    );

    via_port_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .idx     (idx),
        .wdata   (reg_wdata),
        .regs    (regs),
        .bst_chg (bus_chg),
        .bst_old (bus_old),
        .bst_new (bus_new)
    );

    always_comb begin
        case (idx)
            IDX_PB:            reg_rdata = regs.pb;
            IDX_PA, IDX_PA_NH: reg_rdata = regs.pa;
            IDX_DIRB:          reg_rdata = regs.dirb;
            IDX_DIRA:          reg_rdata = regs.dira;
            IDX_SHIFT:         reg_rdata = regs.shift;
            IDX_AUXC:          reg_rdata = regs.auxc;
            IDX_PERC:          reg_rdata = regs.perc;
            IDX_FLAG:          reg_rdata = {irq, flags};
            IDX_ENAB:          reg_rdata = {1'b1, enables};
            default:           reg_rdata = '0;
        endcase
    end

    // R6
    flag_summary_chk: assert property (@(posedge clk) disable iff (rst)
        (idx == IDX_FLAG) |-> (reg_rdata[DATA_W-1] == irq));

    // R11
    hole_read_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr >= 4'd4 && reg_addr <= 4'd9) |-> (reg_rdata == '0));

endmodule

// File: tb/via_irq_unit_test.sv
module via_irq_unit_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [6:0] src_pulse;
    logic       irq;
    logic       bus_chg;
    logic [1:0] bus_old;
    logic [1:0] bus_new;

    always #5 clk = ~clk;

    via_irq_unit uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_pulse(src_pulse),
        .irq(irq), .bus_chg(bus_chg), .bus_old(bus_old), .bus_new(bus_new)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [6:0] m_flag;
    logic [6:0] m_enab;
    logic [7:0] m_reg [16];
    logic       m_chg;
    logic [1:0] m_old, m_new;

    task automatic chk(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got 0x%02h expected 0x%02h", req, what, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [3:0] i);
        case (i)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd10, 4'd11, 4'd12: return m_reg[i];
            4'd15: return m_reg[1];
            4'd13: return {|(m_flag & m_enab), m_flag};
            4'd14: return {1'b1, m_enab};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] i);
        case (i)
            4'd13: return "R6";
            4'd14: return "R5";
            4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: return "R11";
            default: return "R9";
        endcase
    endfunction

    task automatic model_reset();
        m_flag = '0; m_enab = '0; m_chg = 0; m_old = '0; m_new = '0;
        for (int k = 0; k < 16; k++) m_reg[k] = '0;
    endtask

    // One write/pulse cycle followed by a read of rd_idx in the same cycle.
    task automatic step(input logic wr, input logic [3:0] idx, input logic [7:0] wd,
                        input logic [6:0] pulse, input logic [3:0] rd_idx);
        logic [6:0] clr;
        @(negedge clk);
        reg_wr = wr; reg_addr = idx; reg_wdata = wd; src_pulse = pulse;
        @(posedge clk);
        #1;
        clr    = (wr && idx == 4'd13) ? wd[6:0] : 7'h00;
        m_flag = (m_flag & ~clr) | pulse;
        if (wr && idx == 4'd14)
            m_enab = wd[7] ? (m_enab | wd[6:0]) : (m_enab & ~wd[6:0]);
        m_chg = 0;
        if (wr && idx == 4'd0 && wd[5:4] != m_reg[0][5:4]) begin
            m_chg = 1; m_old = m_reg[0][5:4]; m_new = wd[5:4];
        end
        if (wr) begin
            case (idx)
                4'd0, 4'd1, 4'd2, 4'd3, 4'd10, 4'd11, 4'd12: m_reg[idx] = wd;
                4'd15: m_reg[1] = wd;
                default: ;
            endcase
        end
        reg_wr = 0; src_pulse = '0; reg_addr = rd_idx;
        #1;
        chk(tag_of(rd_idx), "rdata", reg_rdata, exp_read(rd_idx));
        chk("R3", "irq", {7'd0, irq}, {7'd0, |(m_flag & m_enab)});
        chk("R10", "bus_chg", {7'd0, bus_chg}, {7'd0, m_chg});
        if (m_chg) chk("R10", "old/new", {4'd0, bus_old, bus_new}, {4'd0, m_old, m_new});
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] wi, ri;
        logic [7:0] wd;
        logic [6:0] pl;
        void'($urandom(32'h5EED_0C1A));
        rst = 1; reg_wr = 0; reg_addr = '0; reg_wdata = '0; src_pulse = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: reset state
        reg_addr = 4'd14; #1; chk("R1", "enab read", reg_rdata, 8'h80);
        reg_addr = 4'd13; #1; chk("R1", "flag read", reg_rdata, 8'h00);
        reg_addr = 4'd1;  #1; chk("R1", "port A", reg_rdata, 8'h00);
        chk("R1", "irq", {7'd0, irq}, 8'h00);
        chk("R1", "bus_chg", {7'd0, bus_chg}, 8'h00);

        // R2: masked pulse still latches, no irq
        step(0, 4'd0, 8'h00, 7'h08, 4'd13);
        chk("R2", "flag3", reg_rdata, 8'h08);
        // R4/R3: enabling a pending flag raises irq in the next cycle
        step(1, 4'd14, 8'h88, 7'h00, 4'd14);
        chk("R4", "enab set", reg_rdata, 8'h88);
        chk("R3", "irq up", {7'd0, irq}, 8'h01);
        // R6: summary bit
        step(0, 4'd0, 8'h00, 7'h00, 4'd13);
        chk("R6", "summary", reg_rdata, 8'h88);
        // R8: clear and pulse on same bit
        step(1, 4'd13, 8'h08, 7'h08, 4'd13);
        chk("R8", "set wins", reg_rdata, 8'h88);
        // R7: clear only selected bit
        step(0, 4'd0, 8'h00, 7'h41, 4'd13);
        step(1, 4'd13, 8'h08, 7'h00, 4'd13);
        chk("R7", "partial clear", reg_rdata, 8'h41);
        chk("R3", "irq down", {7'd0, irq}, 8'h00);
        // R4: clear form
        step(1, 4'd14, 8'h7F, 7'h00, 4'd14);
        chk("R4", "enab clear", reg_rdata, 8'h80);
        // R10: field change and no-change
        step(1, 4'd0, 8'h30, 7'h00, 4'd0);
        chk("R10", "strobe", {7'd0, bus_chg}, 8'h01);
        step(1, 4'd0, 8'h3F, 7'h00, 4'd0);
        chk("R10", "no strobe", {7'd0, bus_chg}, 8'h00);
        // R9: alias index 15 shares port A
        step(1, 4'd15, 8'hA5, 7'h00, 4'd1);
        chk("R9", "alias", reg_rdata, 8'hA5);
        // R11: write to hole leaves all unchanged
        step(1, 4'd6, 8'hFF, 7'h00, 4'd6);
        for (int k = 0; k < 16; k++) begin
            reg_addr = k[3:0]; #1;
            chk(k inside {[4:9]} ? "R11" : tag_of(k[3:0]), "after hole write",
                reg_rdata, exp_read(k[3:0]));
        end

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            wi = $urandom_range(0, 15);
            if ($urandom_range(0, 3) == 0) wi = 4'd13;
            wd = $urandom;
            pl = ($urandom_range(0, 2) == 0) ? 7'($urandom) : 7'h00;
            ri = $urandom_range(0, 15);
            step($urandom_range(0, 1) == 1, wi, wd, pl, ri);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule